// File: doc/BRIEF.md
# Operand Register File Local to One Function Unit

This block is a very small register file that sits in the execute stage beside one function unit of a datapath with two units: a load-store unit and an ALU. It keeps a handful of short-lived values next to the unit that consumes them. Reading them there is far cheaper than going back to the shared backing register file. When enough operand reads land here, the backing file can be built with two read ports instead of four.

The file has two read ports. Both feed only the operand inputs of its owning unit. Each read carries the identity of the requesting unit, and a request from any other unit is refused.

The file has one write port per function unit, so either unit can deposit a result into any entry. This lets the two units hand values to each other. When both write ports hit the same entry in one cycle, the owning unit's write is kept.

Reads are registered. The value returned is the entry's content before any write at the same clock edge. The read happens in the execute stage, alongside operand selection from the forwarding network.

Top module: `local_operand_regs`

## Requirements
- R1: With default parameters the file holds 4 entries of 32 bits, addressed by a 2-bit index, with 2 read ports and 2 write ports.
- R2: A read port whose enable is high in a cycle, with a permitted requester, presents valid = 1 and the addressed entry's data after the next rising clock edge (one cycle of latency).
- R3: A read is permitted only when its requester code equals the owning unit. Codes: 0 = load-store unit, 1 = ALU; the default owner is the ALU. A refused read, or a port with enable low, presents valid = 0 and data = 0 on the next cycle.
- R4: Write port 0 belongs to the load-store unit and port 1 to the ALU. Either port, when its enable is high, stores its 32-bit data into the entry named by its index at the rising clock edge.
- R5: A write port with enable low leaves every entry unchanged, whatever its index and data.
- R6: When both write ports are enabled for the same entry in one cycle, the entry takes the data of the port that belongs to the owning unit.
- R7: A read of an entry that is written at the same clock edge returns the old content. A read in the following cycle returns the new content.
- R8: A synchronous active-high reset clears every entry to zero and drives both read outputs to valid = 0, data = 0.
- R9: Both write ports enabled for different entries in one cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 2 | Write enable per unit port (bit 0 load-store, bit 1 ALU) |
| wr_idx | input | 4 | Entry index per write port, 2 bits each, port 0 in the low bits |
| wr_data | input | 64 | Write data per port, 32 bits each, port 0 in the low bits |
| rd_en | input | 2 | Read enable per read port |
| rd_idx | input | 4 | Entry index per read port, 2 bits each |
| rd_unit | input | 2 | Requesting unit code per read port, 1 bit each |
| rd_vld | output | 2 | Registered read valid per read port |
| rd_data | output | 64 | Registered read data per read port, 32 bits each |

## Verification
The bench builds the block with its default parameters: four 32-bit entries, two read ports, two write ports and the ALU as owner. At that size every entry can be written by both units and read from both ports within a short vector table. A same-entry collision can then be set up where the non-owning load-store unit loses. Requests tagged with the load-store unit's code reach the refusal path. Write-then-read pairs on the same entry and a reset in the middle of the run with nonzero contents complete the corner cases.

// File: rtl/lor_pkg.sv
package lor_pkg;
  localparam int UNIT_LSU = 0;
  localparam int UNIT_ALU = 1;

  // Priority of write port q over write port p when both target one entry.
  function automatic bit outranks(input int q, input int p, input int owner);
    if (q == p) return 1'b0;
    if (q == owner) return 1'b1;
    if (p == owner) return 1'b0;
    return q < p;
  endfunction
endpackage

// File: rtl/lor_wr_merge.sv
module lor_wr_merge #(
  parameter int NUM_UNITS = 2,
  parameter int IDX_W     = 2,
  parameter int OWNER     = 1
) (
  input  logic [NUM_UNITS-1:0]       req_en,
  input  logic [NUM_UNITS*IDX_W-1:0] req_idx,
  output logic [NUM_UNITS-1:0]       grant
);
  always_comb begin
    for (int p = 0; p < NUM_UNITS; p++) begin
      grant[p] = req_en[p];
      for (int q = 0; q < NUM_UNITS; q++) begin
        if (lor_pkg::outranks(q, p, OWNER) && req_en[q] &&
            req_idx[q*IDX_W +: IDX_W] == req_idx[p*IDX_W +: IDX_W])
          grant[p] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/lor_store.sv
module lor_store #(
  parameter int DATA_W    = 32,
  parameter int DEPTH     = 4,
  parameter int NUM_UNITS = 2,
  parameter int IDX_W     = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_UNITS-1:0]          grant,
  input  logic [NUM_UNITS*IDX_W-1:0]    wr_idx,
  input  logic [NUM_UNITS*DATA_W-1:0]   wr_data,
  output logic [DEPTH-1:0][DATA_W-1:0]  entries
);
  always_ff @(posedge clk) begin
    if (rst) begin
      entries <= '0;
    end else begin
      for (int p = 0; p < NUM_UNITS; p++) begin
        if (grant[p])
          entries[wr_idx[p*IDX_W +: IDX_W]] <= wr_data[p*DATA_W +: DATA_W];
      end
    end
  end
endmodule

// File: rtl/lor_rd_port.sv
module lor_rd_port #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  parameter int IDX_W  = 2,
  parameter int UNIT_W = 1,
  parameter int OWNER  = 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         en,
  input  logic [IDX_W-1:0]             idx,
  input  logic [UNIT_W-1:0]            unit,
  input  logic [DEPTH-1:0][DATA_W-1:0] entries,
  output logic                         vld,
  output logic [DATA_W-1:0]            data
);
  logic allowed;
  assign allowed = en && (unit == UNIT_W'(OWNER));

  always_ff @(posedge clk) begin
    if (rst) begin
      vld  <= 1'b0;
      data <= '0;
    end else begin
      vld  <= allowed;
      data <= allowed ? entries[idx] : '0;
    end
  end
endmodule

// File: rtl/local_operand_regs.sv
module local_operand_regs #(
  parameter int DATA_W    = 32,
  parameter int DEPTH     = 4,
  parameter int NUM_UNITS = 2,
  parameter int NUM_RD    = 2,
  parameter int OWNER     = lor_pkg::UNIT_ALU,
  localparam int IDX_W    = $clog2(DEPTH),
  localparam int UNIT_W   = $clog2(NUM_UNITS)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_UNITS-1:0]        wr_en,
  input  logic [NUM_UNITS*IDX_W-1:0]  wr_idx,
  input  logic [NUM_UNITS*DATA_W-1:0] wr_data,
  input  logic [NUM_RD-1:0]           rd_en,
  input  logic [NUM_RD*IDX_W-1:0]     rd_idx,
  input  logic [NUM_RD*UNIT_W-1:0]    rd_unit,
  output logic [NUM_RD-1:0]           rd_vld,
  output logic [NUM_RD*DATA_W-1:0]    rd_data
);
  logic [NUM_UNITS-1:0]         grant;
  logic [DEPTH-1:0][DATA_W-1:0] entries;

  lor_wr_merge #(.NUM_UNITS(NUM_UNITS), .IDX_W(IDX_W), .OWNER(OWNER)) u_merge (
    .req_en (wr_en),
    .req_idx(wr_idx),
    .grant  (grant)
  );

  lor_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .NUM_UNITS(NUM_UNITS), .IDX_W(IDX_W)) u_store (
    .clk    (clk),
    .rst    (rst),
    .grant  (grant),
    .wr_idx (wr_idx),
    .wr_data(wr_data),
    .entries(entries)
  );

  for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
    lor_rd_port #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W),
                  .UNIT_W(UNIT_W), .OWNER(OWNER)) u_port (
      .clk    (clk),
      .rst    (rst),
      .en     (rd_en[r]),
      .idx    (rd_idx[r*IDX_W +: IDX_W]),
      .unit   (rd_unit[r*UNIT_W +: UNIT_W]),
      .entries(entries),
      .vld    (rd_vld[r]),
      .data   (rd_data[r*DATA_W +: DATA_W])
    );
  end
endmodule

// File: rtl/lor_checker.sv
module lor_checker #(
  parameter int DATA_W    = 32,
  parameter int DEPTH     = 4,
  parameter int NUM_UNITS = 2,
  parameter int NUM_RD    = 2,
  parameter int OWNER     = 1,
  parameter int IDX_W     = 2,
  parameter int UNIT_W    = 1
) (
  input logic                        clk,
  input logic                        rst,
  input logic [NUM_UNITS-1:0]        wr_en,
  input logic [NUM_UNITS*IDX_W-1:0]  wr_idx,
  input logic [NUM_UNITS*DATA_W-1:0] wr_data,
  input logic [NUM_RD-1:0]           rd_en,
  input logic [NUM_RD*UNIT_W-1:0]    rd_unit,
  input logic [NUM_RD-1:0]           rd_vld,
  input logic [NUM_RD*DATA_W-1:0]    rd_data,
  input logic [DEPTH-1:0][DATA_W-1:0] entries
);
  for (genvar r = 0; r < NUM_RD; r++) begin : g_rd_chk
    assert_owner_only_R3: assert property (@(posedge clk) disable iff (rst)
      rd_vld[r] |-> $past(rd_en[r] && rd_unit[r*UNIT_W +: UNIT_W] == UNIT_W'(OWNER)));
    assert_refused_zero_R3: assert property (@(posedge clk) disable iff (rst)
      !rd_vld[r] |-> rd_data[r*DATA_W +: DATA_W] == '0);
  end

  assert_owner_lands_R4: assert property (@(posedge clk) disable iff (rst)
    wr_en[OWNER] |=> entries[$past(wr_idx[OWNER*IDX_W +: IDX_W])] ==
                     $past(wr_data[OWNER*DATA_W +: DATA_W]));

  for (genvar q = 0; q < NUM_UNITS; q++) begin : g_coll_chk
    if (q != OWNER) begin : g_other
      assert_owner_wins_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en[q] && wr_en[OWNER] &&
         wr_idx[q*IDX_W +: IDX_W] == wr_idx[OWNER*IDX_W +: IDX_W])
        |=> entries[$past(wr_idx[OWNER*IDX_W +: IDX_W])] ==
            $past(wr_data[OWNER*DATA_W +: DATA_W]));
    end
  end

  assert_reset_clears_R8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (entries == '0 && rd_vld == '0));
endmodule

bind local_operand_regs lor_checker #(
  .DATA_W(DATA_W), .DEPTH(DEPTH), .NUM_UNITS(NUM_UNITS), .NUM_RD(NUM_RD),
  .OWNER(OWNER), .IDX_W(IDX_W), .UNIT_W(UNIT_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
  .rd_en(rd_en), .rd_unit(rd_unit), .rd_vld(rd_vld), .rd_data(rd_data),
  .entries(entries)
);

// File: tb/sim_local_operand_regs.sv
module sim_local_operand_regs;
  typedef struct packed {
    logic        we0; logic [1:0] wi0; logic [31:0] wd0;
    logic        we1; logic [1:0] wi1; logic [31:0] wd1;
    logic        rea; logic [1:0] ia;  logic        ua;
    logic        reb; logic [1:0] ib;  logic        ub;
    logic        xva; logic [31:0] xa;
    logic        xvb; logic [31:0] xb;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t TBL [NV] = '{
    // R9, R7: two writes to different entries, reads see old zeros
    '{1'b1, 2'd0, 32'h1111_1111, 1'b1, 2'd1, 32'h2222_2222,
      1'b1, 2'd0, 1'b1, 1'b1, 2'd1, 1'b1, 1'b1, 32'h0, 1'b1, 32'h0},
    // R2, R4: new contents visible the next cycle
    '{1'b0, 2'd0, 32'h0, 1'b0, 2'd0, 32'h0,
      1'b1, 2'd0, 1'b1, 1'b1, 2'd1, 1'b1, 1'b1, 32'h1111_1111, 1'b1, 32'h2222_2222},
    // R6 setup, R3: collision on entry 2, foreign read on port b refused
    '{1'b1, 2'd2, 32'hAAAA_0000, 1'b1, 2'd2, 32'hBBBB_0000,
      1'b1, 2'd2, 1'b1, 1'b1, 2'd0, 1'b0, 1'b1, 32'h0, 1'b0, 32'h0},
    // R6: owner data kept; R3 refused again; LSU writes entry 3
    '{1'b1, 2'd3, 32'h3333_3333, 1'b0, 2'd0, 32'h0,
      1'b1, 2'd2, 1'b1, 1'b1, 2'd2, 1'b0, 1'b1, 32'hBBBB_0000, 1'b0, 32'h0},
    // R7: ALU overwrites entry 3 while both ports read it
    '{1'b0, 2'd0, 32'h0, 1'b1, 2'd3, 32'h4444_4444,
      1'b1, 2'd3, 1'b1, 1'b1, 2'd3, 1'b1, 1'b1, 32'h3333_3333, 1'b1, 32'h3333_3333},
    // R7: new value next cycle; R3 disabled port b gives zeros
    '{1'b0, 2'd0, 32'h0, 1'b0, 2'd0, 32'h0,
      1'b1, 2'd3, 1'b1, 1'b0, 2'd0, 1'b1, 1'b1, 32'h4444_4444, 1'b0, 32'h0},
    // R5: disabled writes carrying data
    '{1'b0, 2'd0, 32'hFFFF_FFFF, 1'b0, 2'd1, 32'hEEEE_EEEE,
      1'b1, 2'd0, 1'b1, 1'b1, 2'd1, 1'b1, 1'b1, 32'h1111_1111, 1'b1, 32'h2222_2222},
    // R5: entries 0 and 1 still hold their values
    '{1'b0, 2'd0, 32'h0, 1'b0, 2'd0, 32'h0,
      1'b1, 2'd0, 1'b1, 1'b1, 2'd1, 1'b1, 1'b1, 32'h1111_1111, 1'b1, 32'h2222_2222}
  };

  function automatic string tag_of(input int i);
    case (i)
      0: return "R9/R7";
      1: return "R2/R4";
      2: return "R3";
      3: return "R6/R3";
      4: return "R7";
      5: return "R7/R3";
      default: return "R5";
    endcase
  endfunction

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  wr_en = '0;
  logic [3:0]  wr_idx = '0;
  logic [63:0] wr_data = '0;
  logic [1:0]  rd_en = '0;
  logic [3:0]  rd_idx = '0;
  logic [1:0]  rd_unit = '0;
  logic [1:0]  rd_vld;
  logic [63:0] rd_data;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  local_operand_regs u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_unit(rd_unit),
    .rd_vld(rd_vld), .rd_data(rd_data)
  );

  task automatic check_port(input int p, input logic xv, input logic [31:0] xd,
                            input string tag);
    logic        v;
    logic [31:0] d;
    v = rd_vld[p];
    d = rd_data[p*32 +: 32];
    n_chk++;
    if (v !== xv || d !== xd) begin
      n_bad++;
      $display("FAIL %s port %0d: got vld=%b data=%h, expected vld=%b data=%h",
               tag, p, v, d, xv, xd);
    end
  endtask

  task automatic apply(input vec_t v);
    wr_en   = {v.we1, v.we0};
    wr_idx  = {v.wi1, v.wi0};
    wr_data = {v.wd1, v.wd0};
    rd_en   = {v.reb, v.rea};
    rd_idx  = {v.ib, v.ia};
    rd_unit = {v.ub, v.ua};
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R8: reset state, with an owner read requested during reset
    rd_en = 2'b11; rd_unit = 2'b11;
    repeat (2) @(posedge clk);
    #1;
    check_port(0, 1'b0, 32'h0, "R8");
    check_port(1, 1'b0, 32'h0, "R8");
    @(negedge clk);
    rst = 1'b0;

    // R1..R7, R9: table walk, check after the edge that registers the read
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      apply(TBL[i]);
      @(posedge clk);
      #1;
      check_port(0, TBL[i].xva, TBL[i].xa, tag_of(i));
      check_port(1, TBL[i].xvb, TBL[i].xb, tag_of(i));
    end

    // R8: reset in mid-run with nonzero contents
    @(negedge clk);
    wr_en = '0; rst = 1'b1;
    rd_en = 2'b11; rd_unit = 2'b11; rd_idx = {2'd3, 2'd2};
    @(posedge clk);
    #1;
    check_port(0, 1'b0, 32'h0, "R8");
    check_port(1, 1'b0, 32'h0, "R8");
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    check_port(0, 1'b1, 32'h0, "R8");
    check_port(1, 1'b1, 32'h0, "R8");

    // R4: the load-store port writes the highest index, owner reads it back
    @(negedge clk);
    wr_en = 2'b01; wr_idx = {2'd0, 2'd3}; wr_data = {32'h0, 32'hC0DE_0003};
    rd_en = 2'b00;
    @(negedge clk);
    wr_en = '0; rd_en = 2'b01; rd_idx = {2'd0, 2'd3}; rd_unit = 2'b01;
    @(posedge clk);
    #1;
    check_port(0, 1'b1, 32'hC0DE_0003, "R4");
    check_port(1, 1'b0, 32'h0, "R3");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule